// File: doc/BRIEF.md
# System Management Interrupt Entry Sequencer

This block sits next to a simple CPU core model and decides when the core enters system management mode. A request arrives on an active-low pin with no clock relationship to the core. The block passes it through a two-flop synchronizer and detects its falling edge. It holds the request until the core reports an instruction boundary and is not shut down. It then waits until the bus has no outstanding cycles, pipelined ones included. After that it runs a fixed-length save phase and, on the last save cycle, loads the register values that the handler expects.

While the save phase and the handler run, an active-low acknowledge output stays low. The handler finishes with a one-cycle exit pulse, which returns the block to idle. Requests that arrive during an entry in progress or inside the handler are folded into a single held request. That request is serviced after the exit, so entries never nest. The loaded context places the handler at linear address 38000H: the code segment base is 30000H and the instruction pointer is 8000H. Control register 0 and the debug control value come from core inputs, with the defined bits cleared.

Top module: `smm_entry_seq`

## Requirements
- R1: An entry starts only on a high-to-low transition of `req_n`. A level that stays low after an exit starts no further entry.
- R2: A detected request waits in the pending state until `insn_boundary` is high. No save phase starts while it is low.
- R3: After acceptance, the save phase starts only once `bus_busy` is low. `bus_busy` high covers every outstanding cycle, pipelined ones included.
- R4: `ack_n` goes low in the first save cycle and stays low through the save phase and the handler. `ctx_load` pulses high for one cycle in the first handler cycle, `SAVE_CYCLES` (4) cycles after `ack_n` fell. Out of reset `ack_n` is 1 and `ctx_load` is 0.
- R5: While `shutdown` is high, a pending request is not accepted. It proceeds once `shutdown` drops.
- R6: Any number of falling edges while a request is pending gives exactly one entry. An edge inside the handler does not start a nested entry.
- R7: On load, `cs_sel` is 3000H, `cs_base` is 00030000H and `ip` is 00008000H, so `cs_base + ip` is 38000H.
- R8: On load, `flags` is 00000002H, `dseg_sel` and `dseg_base` are 0, and `seg_limit` is FFFFFH.
- R9: On load, `cr0_out` equals `cr0_in` with bits 0, 1, 2, 3 and 31 cleared. `dr7_out` equals `dr7_in` with bits 0 to 10 and 16 to 31 cleared, so only bits 11 to 15 survive.
- R10: A falling edge seen during the save phase or the handler is held. An `exit_pulse` in the handler drives `ack_n` high on the next clock, and the held request then starts a fresh entry.
- R11: `exit_pulse` has no effect outside the handler state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 1 | Asynchronous active-low management request |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| bus_busy | input | 1 | Bus cycles outstanding, pipelined ones included |
| shutdown | input | 1 | Core is in shutdown |
| exit_pulse | input | 1 | One-cycle handler exit |
| cr0_in | input | 32 | Current control register 0 value |
| dr7_in | input | 32 | Current debug control value |
| ack_n | output | 1 | Active-low management mode acknowledge |
| ctx_load | output | 1 | One-cycle strobe: context outputs were loaded |
| cs_sel | output | 16 | Code segment selector |
| cs_base | output | 32 | Code segment base |
| ip | output | 32 | Instruction pointer |
| flags | output | 32 | Flags register |
| dseg_sel | output | 16 | Selector for all data and stack segments |
| dseg_base | output | 32 | Base for all data and stack segments |
| seg_limit | output | 20 | Limit for every segment |
| cr0_out | output | 32 | Masked control register 0 |
| dr7_out | output | 32 | Masked debug control value |

## Verification
The bench holds `insn_boundary` low, `bus_busy` high or `shutdown` high for many cycles after a request. A design that skipped any of these gates would drop `ack_n` too early. It toggles `req_n` several times while a request waits and again inside the handler. A sequencer that re-armed on each edge would count more than one load, or nest. It also leaves `req_n` low across an exit, which a level-sensitive detector would turn into a second entry. It pulses `exit_pulse` in idle and while the bus drains, and feeds random control register values. This exposes a misplaced clear mask and an exit that is not gated on the handler state.

// File: rtl/smm_entry_seq.sv
module smm_entry_seq #(
  parameter int SAVE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_n,
  input  logic        insn_boundary,
  input  logic        bus_busy,
  input  logic        shutdown,
  input  logic        exit_pulse,
  input  logic [31:0] cr0_in,
  input  logic [31:0] dr7_in,
  output logic        ack_n,
  output logic        ctx_load,
  output logic [15:0] cs_sel,
  output logic [31:0] cs_base,
  output logic [31:0] ip,
  output logic [31:0] flags,
  output logic [15:0] dseg_sel,
  output logic [31:0] dseg_base,
  output logic [19:0] seg_limit,
  output logic [31:0] cr0_out,
  output logic [31:0] dr7_out
);
  localparam int CW = (SAVE_CYCLES > 1) ? $clog2(SAVE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SAVE_CYCLES - 1);
  localparam logic [15:0] ENTRY_SEL  = 16'h3000;
  localparam logic [31:0] ENTRY_IP   = 32'h0000_8000;
  localparam logic [31:0] ENTRY_FLG  = 32'h0000_0002;
  localparam logic [19:0] ENTRY_LIM  = 20'hF_FFFF;
  localparam logic [31:0] CR0_CLR    = 32'h8000_000F;
  localparam logic [31:0] DR7_KEEP   = 32'h0000_F800;

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_DRAIN, S_SAVE, S_ACT} seq_t;
  seq_t state, state_nx;

  logic          sy1, sy2, sy3, held;
  logic [CW-1:0] cnt;
  logic          fall, save_done;

  assign fall      = sy3 & ~sy2;
  assign save_done = (state == S_SAVE) && (cnt == CNT_LAST);
  assign ack_n     = !((state == S_SAVE) || (state == S_ACT));

  always_ff @(posedge clk) begin
    if (!rst_n) {sy1, sy2, sy3} <= 3'b111;
    else        {sy3, sy2, sy1} <= {sy2, sy1, req_n};
  end

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (fall || held)                   state_nx = S_PEND;
      S_PEND:  if (insn_boundary && !shutdown)     state_nx = S_DRAIN;
      S_DRAIN: if (!bus_busy)                      state_nx = S_SAVE;
      S_SAVE:  if (save_done)                      state_nx = S_ACT;
      S_ACT:   if (exit_pulse)                     state_nx = S_IDLE;
      default:                                     state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      held  <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE)                held <= 1'b0;
      else if (fall && state != S_PEND)   held <= 1'b1;
      if (state != S_SAVE)                cnt  <= '0;
      else if (!save_done)                cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_load  <= 1'b0;
      cs_sel    <= '0;
      cs_base   <= '0;
      ip        <= '0;
      flags     <= '0;
      dseg_sel  <= '0;
      dseg_base <= '0;
      seg_limit <= '0;
      cr0_out   <= '0;
      dr7_out   <= '0;
    end else begin
      ctx_load <= save_done;
      if (save_done) begin
        cs_sel    <= ENTRY_SEL;
        cs_base   <= {12'h0, ENTRY_SEL, 4'h0};
        ip        <= ENTRY_IP;
        flags     <= ENTRY_FLG;
        dseg_sel  <= '0;
        dseg_base <= '0;
        seg_limit <= ENTRY_LIM;
        cr0_out   <= cr0_in & ~CR0_CLR;
        dr7_out   <= dr7_in & DR7_KEEP;
      end
    end
  end

  p_boundary_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PEND && !insn_boundary) |=> (state == S_PEND));
  p_drain_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN && bus_busy) |=> (state == S_DRAIN && ack_n));
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !exit_pulse) |=> !ack_n);
  p_load_after_save_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (!ack_n && $past(state == S_SAVE)));
  p_no_shutdown_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PEND && shutdown) |=> ack_n);
  p_entry_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (cs_base + ip == 32'h0003_8000));
  p_cr0_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (cr0_out == ($past(cr0_in) & ~CR0_CLR)));
  p_exit_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACT && exit_pulse) |=> ack_n);
  p_exit_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && exit_pulse) |=> !ctx_load);
endmodule

// File: tb/smm_entry_seq_test.sv
module smm_entry_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0;
  logic req_n = 1, insn_boundary = 1, bus_busy = 0, shutdown = 0, exit_pulse = 0;
  logic [31:0] cr0_in = 32'hFFFF_FFFF, dr7_in = 32'hFFFF_FFFF;
  logic ack_n, ctx_load;
  logic [15:0] cs_sel, dseg_sel;
  logic [31:0] cs_base, ip, flags, dseg_base, cr0_out, dr7_out;
  logic [19:0] seg_limit;

  smm_entry_seq uut (.clk, .rst_n, .req_n, .insn_boundary, .bus_busy, .shutdown,
    .exit_pulse, .cr0_in, .dr7_in, .ack_n, .ctx_load, .cs_sel, .cs_base, .ip,
    .flags, .dseg_sel, .dseg_base, .seg_limit, .cr0_out, .dr7_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, loads = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: states 0 idle,1 waiting,2 draining,3 saving,4 handler
  int m_state = 0, m_cnt = 0;
  bit m_held = 0, m_load = 0;
  bit q[$] = '{1, 1, 1};
  logic [31:0] m_cr0 = 0, m_dr7 = 0;
  logic [15:0] m_cs = 0;
  logic [31:0] m_ip = 0, m_flg = 0;
  logic [19:0] m_lim = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_held = 0; m_load = 0; q = '{1, 1, 1};
      m_cr0 = 0; m_dr7 = 0; m_cs = 0; m_ip = 0; m_flg = 0; m_lim = 0;
    end else begin
      bit f;
      f = q[0] && !q[1];
      q.push_back(req_n);
      void'(q.pop_front());
      m_load = 0;
      case (m_state)
        0: if (f || m_held) begin m_state = 1; m_held = 0; end
        1: if (insn_boundary && !shutdown) m_state = 2;
        2: begin if (f) m_held = 1; if (!bus_busy) begin m_state = 3; m_cnt = 0; end end
        3: begin
          if (f) m_held = 1;
          if (m_cnt == 3) begin
            m_state = 4; m_load = 1;
            m_cs = 16'h3000; m_ip = 32'h8000; m_flg = 32'h2; m_lim = 20'hFFFFF;
            m_cr0 = cr0_in & 32'h7FFF_FFF0; m_dr7 = dr7_in & 32'h0000_F800;
          end else m_cnt++;
        end
        4: begin if (f) m_held = 1; if (exit_pulse) m_state = 0; end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      bit m_ack;
      m_ack = !(m_state == 3 || m_state == 4);
      chk(ack_n == m_ack, "R4 ack_n", 32'(ack_n), 32'(m_ack));
      chk(ctx_load == m_load, "R4 ctx_load", 32'(ctx_load), 32'(m_load));
      chk(cs_sel == m_cs && cs_base == {12'h0, m_cs, 4'h0} && ip == m_ip, "R7 code ctx", cs_base, {12'h0, m_cs, 4'h0});
      chk(flags == m_flg && seg_limit == m_lim && dseg_sel == 0 && dseg_base == 0, "R8 data ctx", flags, m_flg);
      chk(cr0_out == m_cr0, "R9 cr0", cr0_out, m_cr0);
      chk(dr7_out == m_dr7, "R9 dr7", dr7_out, m_dr7);
      if (ctx_load) loads++;
    end
    if (cycles > WATCHDOG && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_req(input int lo);
    req_n = 0; wait_n(lo); req_n = 1; wait_n(1);
  endtask
  task automatic do_exit();
    exit_pulse = 1; wait_n(1); exit_pulse = 0;
  endtask

  initial begin
    wait_n(4);
    chk(ack_n === 1'b1, "R4 reset ack_n", 32'(ack_n), 1);
    chk(ctx_load === 1'b0, "R4 reset ctx_load", 32'(ctx_load), 0);
    rst_n = 1;
    wait_n(2);

    // basic entry
    pulse_req(2); wait_n(12);
    chk(ack_n == 0, "R4 entered", 32'(ack_n), 0);
    chk(cs_sel == 16'h3000, "R7 cs_sel", 32'(cs_sel), 32'h3000);
    chk(cs_base + ip == 32'h38000, "R7 entry address", cs_base + ip, 32'h38000);
    chk(flags == 32'h2 && seg_limit == 20'hFFFFF && dseg_base == 0, "R8 values", flags, 32'h2);
    chk(cr0_out == 32'h7FFF_FFF0, "R9 cr0 mask", cr0_out, 32'h7FFF_FFF0);
    chk(dr7_out == 32'h0000_F800, "R9 dr7 mask", dr7_out, 32'h0000_F800);
    do_exit(); wait_n(1);
    chk(ack_n == 1, "R10 release", 32'(ack_n), 1);

    // level held low: one entry only
    req_n = 0; wait_n(14);
    chk(ack_n == 0, "R1 edge entry", 32'(ack_n), 0);
    do_exit(); wait_n(20);
    chk(ack_n == 1, "R1 level ignored", 32'(ack_n), 1);
    req_n = 1; wait_n(4);

    // instruction boundary gate
    insn_boundary = 0; pulse_req(2); wait_n(15);
    chk(ack_n == 1, "R2 waits boundary", 32'(ack_n), 1);
    insn_boundary = 1; wait_n(8);
    chk(ack_n == 0, "R2 accepted", 32'(ack_n), 0);
    do_exit(); wait_n(3);

    // bus drain gate
    bus_busy = 1; pulse_req(2); wait_n(15);
    chk(ack_n == 1, "R3 waits drain", 32'(ack_n), 1);
    bus_busy = 0; wait_n(8);
    chk(ack_n == 0, "R3 drained", 32'(ack_n), 0);
    do_exit(); wait_n(3);

    // shutdown gate
    shutdown = 1; pulse_req(2); wait_n(15);
    chk(ack_n == 1, "R5 blocked in shutdown", 32'(ack_n), 1);
    shutdown = 0; wait_n(8);
    chk(ack_n == 0, "R5 accepted after shutdown", 32'(ack_n), 0);
    do_exit(); wait_n(3);

    // merged edges while pending
    loads = 0; insn_boundary = 0;
    for (int i = 0; i < 3; i++) begin pulse_req(3); wait_n(2); end
    insn_boundary = 1; wait_n(30);
    chk(loads == 1, "R6 merged entries", 32'(loads), 1);
    do_exit(); wait_n(20);
    chk(loads == 1 && ack_n == 1, "R6 no extra entry", 32'(loads), 1);

    // edge inside the handler is held, not nested
    loads = 0; pulse_req(2); wait_n(12);
    pulse_req(2); wait_n(10);
    chk(loads == 1 && ack_n == 0, "R6 no nesting", 32'(loads), 1);
    do_exit(); wait_n(1);
    chk(ack_n == 1, "R10 release before reentry", 32'(ack_n), 1);
    wait_n(12);
    chk(ack_n == 0 && loads == 2, "R10 held reentry", 32'(loads), 2);
    do_exit(); wait_n(3);

    // exit outside handler
    do_exit(); wait_n(5);
    chk(ack_n == 1 && loads == 2, "R11 exit in idle", 32'(ack_n), 1);
    bus_busy = 1; pulse_req(2); wait_n(6);
    do_exit(); wait_n(3); bus_busy = 0; wait_n(8);
    chk(ack_n == 0, "R11 exit in drain ignored", 32'(ack_n), 0);
    do_exit(); wait_n(3);

    // random control values
    for (int i = 0; i < 4; i++) begin
      logic [31:0] c, d;
      c = $urandom; d = $urandom;
      cr0_in = c; dr7_in = d;
      pulse_req(2); wait_n(12);
      chk(cr0_out == (c & ~32'h8000_000F), "R9 random cr0", cr0_out, c & ~32'h8000_000F);
      chk(dr7_out == (d & 32'h0000_F800), "R9 random dr7", dr7_out, d & 32'h0000_F800);
      do_exit(); wait_n(3);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule